// File: doc/BRIEF.md
# Switchable Depth Receive FIFO

This block buffers received bytes for a 16550-style serial controller. It has two depths and switches between them at run time. In legacy mode it holds a single byte. In buffered mode it holds up to sixteen bytes. Bit 0 of a write-only control byte selects the mode. Whenever that bit changes value, the buffer is emptied.

Bytes come from one of two sources, chosen by a loopback select. With loopback off, they come from the serial receive path. With loopback on, they come from writes to the transmit holding register. Reading the data register pops the oldest byte. The block drives a data-ready level and a sticky overrun flag for the line status register.

The stored control byte is brought out so that a neighbouring block can decode the trigger field. Trigger-level interrupts, receive timeouts and DMA signalling are not computed here. Their bits are only held.

Top module: `rx_depth_fifo`

## Requirements
- R1: After reset the stored control byte is 0x00, the depth is 1, the occupancy is 0, data-ready and overrun are low, and the read data is 0xFF.
- R2: In legacy mode (control bit 0 clear) a byte offered while one byte is held is dropped and sets overrun. The held byte stays intact.
- R3: A control write whose bit 0 differs from the stored bit 0 empties the buffer. Enabling sets the depth to 16, and bytes then come out in arrival order.
- R4: A control write with bit 0 clear stores 0x00, whatever its other bits. If it disables buffered mode, the depth returns to 1 and the buffer is emptied.
- R5: A control write with bit 0 set keeps only bits 7, 6, 3 and 0 (mask 0xC9). If it also has bit 1 set, the buffer is emptied.
- R6: In buffered mode, a byte offered while sixteen are held is dropped and sets overrun. The sixteen held bytes are unchanged.
- R7: Data-ready is high exactly when the occupancy is non-zero, with no cycle of delay.
- R8: Overrun is cleared by a line-status read, taking effect the next cycle. If a drop happens in the same cycle as the read, overrun stays set.
- R9: A data read while the buffer is empty returns 0xFF and changes neither the occupancy nor the read position.
- R10: A push and a pop in the same cycle on a non-empty buffer both succeed, and the occupancy is unchanged. This holds even when the buffer is full, and it sets no overrun.
- R11: With loopback on, transmit-register writes are pushed and the receive input is ignored. With loopback off, the reverse applies.
- R12: In a cycle where a control write empties the buffer, a byte offered in that same cycle is discarded and sets no overrun.
- R13: Read and write positions wrap modulo the current depth, so arrival order holds across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_en_i | input | 1 | Loopback select: 1 takes bytes from the transmit register |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_wr_i | input | 1 | Transmit holding register write strobe |
| tx_data_i | input | 8 | Transmit holding register write data |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data (bit 0 enable, bit 1 receive flush, bit 3 DMA mode, bits 7:6 trigger) |
| data_rd_i | input | 1 | Data register read strobe (pops one byte) |
| lsr_rd_i | input | 1 | Line status register read strobe (clears overrun) |
| rd_data_o | output | 8 | Oldest held byte, or 0xFF when empty |
| data_ready_o | output | 1 | Buffer not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| count_o | output | 5 | Occupancy, 0 to 16 |
| ctl_o | output | 8 | Stored control byte |

## Verification
The assertions assume that every strobe is a known 0 or 1 once reset is released. They also assume that a data read is a one-cycle pulse, judged against the occupancy already held in the buffer. The stimulus drives all strobes on the falling edge and raises each one for exactly one cycle. It changes the loopback select only between transfers. It combines a push with a control write only in the flush-priority case, so every cycle matches one of the scenarios the requirements name.

// File: rtl/rx_depth_fifo_pkg.sv
`timescale 1ns/1ps
package rx_depth_fifo_pkg;
  localparam int unsigned CTL_W       = 8;
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_CLR_BIT = 1;
  localparam logic [CTL_W-1:0] CTL_KEEP_MASK = 8'hC9;
endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
  import rx_depth_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             flush_o,
  output logic             deep_o
);
  logic [CTL_W-1:0] ctl_q;
  logic mode_flip, clr_req;

  assign mode_flip = wdata_i[CTL_EN_BIT] ^ ctl_q[CTL_EN_BIT];
  assign clr_req   = wdata_i[CTL_EN_BIT] & wdata_i[CTL_CLR_BIT];
  assign flush_o   = wr_i & (mode_flip | clr_req);
  assign deep_o    = ctl_q[CTL_EN_BIT];
  assign ctl_o     = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i[CTL_EN_BIT] ? (wdata_i & CTL_KEEP_MASK) : '0;
  end

  assert_off_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CTL_EN_BIT]) |=> (ctl_o == '0));
  assert_keep_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CTL_EN_BIT]) |=> (((ctl_o & ~CTL_KEEP_MASK) == '0) && ctl_o[CTL_EN_BIT]));
  assert_ctl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctl_o));
endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAX_DEPTH    = 16,
  parameter int unsigned LEGACY_DEPTH = 1,
  parameter logic [DATA_W-1:0] EMPTY_FILL = '1,
  localparam int unsigned PTR_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deep_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              drop_o
);
  logic [CNT_W-1:0]  depth, count_q;
  logic [PTR_W-1:0]  last_idx, wptr_q, rptr_q;
  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic empty, full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] last);
    return (p == last) ? '0 : p + PTR_W'(1);
  endfunction

  assign depth    = deep_i ? CNT_W'(MAX_DEPTH) : CNT_W'(LEGACY_DEPTH);
  assign last_idx = deep_i ? PTR_W'(MAX_DEPTH - 1) : PTR_W'(LEGACY_DEPTH - 1);
  assign empty    = (count_q == '0);
  assign full     = (count_q >= depth);
  assign do_pop   = pop_i & ~empty & ~flush_i;
  // a pop in the same cycle frees the slot the push needs
  assign do_push  = push_i & ~flush_i & (~full | do_pop);
  assign drop_o   = push_i & ~flush_i & full & ~do_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= step(wptr_q, last_idx);
      if (do_pop)  rptr_q <= step(rptr_q, last_idx);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i) begin
      if (do_push && (wptr_q == PTR_W'(g))) slot_q <= push_data_i;
    end
    assign mem[g] = slot_q;
  end

  assign rd_data_o = empty ? EMPTY_FILL : mem[rptr_q];
  assign count_o   = count_q;
  assign empty_o   = empty;

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= depth);
  assert_flush_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
  assert_empty_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !flush_i) |=> ($stable(rptr_q) && (count_q == '0)));
  assert_push_pop_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty && !flush_i) |=> $stable(count_q));
  assert_drop_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> ($stable(wptr_q) && $stable(count_q)));
endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic lsr_rd_i,
  input  logic empty_i,
  output logic data_ready_o,
  output logic overrun_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (drop_i)   ovr_q <= 1'b1;  // new event beats the clearing read
    else if (lsr_rd_i) ovr_q <= 1'b0;
  end

  assign overrun_o    = ovr_q;
  assign data_ready_o = ~empty_i;

  assert_ovr_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> overrun_o);
  assert_ovr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !drop_i) |=> !overrun_o);
  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !lsr_rd_i) |=> overrun_o);
endmodule

// File: rtl/rx_depth_fifo.sv
`timescale 1ns/1ps
module rx_depth_fifo
  import rx_depth_fifo_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAX_DEPTH    = 16,
  parameter int unsigned LEGACY_DEPTH = 1,
  localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loop_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ctl_wr_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              data_rd_i,
  input  logic              lsr_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTL_W-1:0]  ctl_o
);
  logic              flush, deep, push, empty, drop;
  logic [DATA_W-1:0] push_data;

  assign push      = loop_en_i ? tx_wr_i   : rx_valid_i;
  assign push_data = loop_en_i ? tx_data_i : rx_data_i;

  rxq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl_o),
    .flush_o (flush),
    .deep_o  (deep)
  );

  rxq_store #(
    .DATA_W       (DATA_W),
    .MAX_DEPTH    (MAX_DEPTH),
    .LEGACY_DEPTH (LEGACY_DEPTH)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .deep_i      (deep),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (data_rd_i),
    .rd_data_o   (rd_data_o),
    .count_o     (count_o),
    .empty_o     (empty),
    .drop_o      (drop)
  );

  rxq_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .drop_i       (drop),
    .lsr_rd_i     (lsr_rd_i),
    .empty_i      (empty),
    .data_ready_o (data_ready_o),
    .overrun_o    (overrun_o)
  );

  assert_ignored_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_wr_i && !rx_valid_i && !data_rd_i && !ctl_wr_i) |=> $stable(count_o));
endmodule

// File: tb/rx_depth_fifo_test.sv
`timescale 1ns/1ps
module rx_depth_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_en = 1'b0, rx_valid = 1'b0, tx_wr = 1'b0, ctl_wr = 1'b0;
  logic data_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rx_data = '0, tx_data = '0, ctl_wdata = '0;
  logic [7:0] rd_data, ctl_q;
  logic dr, ovr;
  logic [4:0] cnt;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_depth_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .loop_en_i(loop_en),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .data_rd_i(data_rd), .lsr_rd_i(lsr_rd),
    .rd_data_o(rd_data), .data_ready_o(dr), .overrun_o(ovr),
    .count_o(cnt), .ctl_o(ctl_q)
  );

  localparam logic [3:0] OP_PUSH = 4'd0, OP_POP = 4'd1, OP_CTL = 4'd2,
                         OP_CNT = 4'd3, OP_STAT = 4'd4, OP_LSR = 4'd5, OP_CFG = 4'd6;
  localparam int NV = 33;
  // {op, requirement number, argument, expected}
  localparam logic [23:0] VEC [NV] = '{
    {OP_CNT, 4'd1, 8'h00, 8'h00},
    {OP_PUSH,4'd2, 8'h11, 8'h00},
    {OP_CNT, 4'd2, 8'h00, 8'h01},
    {OP_PUSH,4'd2, 8'h22, 8'h00},
    {OP_LSR, 4'd8, 8'h00, 8'h03},
    {OP_STAT,4'd8, 8'h00, 8'h01},
    {OP_POP, 4'd2, 8'h00, 8'h11},
    {OP_POP, 4'd9, 8'h00, 8'hFF},
    {OP_CNT, 4'd9, 8'h00, 8'h00},
    {OP_STAT,4'd7, 8'h00, 8'h00},
    {OP_CTL, 4'd5, 8'hFF, 8'h00},
    {OP_CFG, 4'd5, 8'h00, 8'hC9},
    {OP_CNT, 4'd3, 8'h00, 8'h00},
    {OP_PUSH,4'd3, 8'h31, 8'h00},
    {OP_PUSH,4'd3, 8'h32, 8'h00},
    {OP_PUSH,4'd3, 8'h33, 8'h00},
    {OP_CNT, 4'd3, 8'h00, 8'h03},
    {OP_POP, 4'd3, 8'h00, 8'h31},
    {OP_CTL, 4'd5, 8'h03, 8'h00},
    {OP_CFG, 4'd5, 8'h00, 8'h01},
    {OP_CNT, 4'd5, 8'h00, 8'h00},
    {OP_PUSH,4'd4, 8'h41, 8'h00},
    {OP_PUSH,4'd4, 8'h42, 8'h00},
    {OP_CTL, 4'd4, 8'h00, 8'h00},
    {OP_CFG, 4'd4, 8'h00, 8'h00},
    {OP_CNT, 4'd4, 8'h00, 8'h00},
    {OP_PUSH,4'd4, 8'h51, 8'h00},
    {OP_PUSH,4'd4, 8'h52, 8'h00},
    {OP_LSR, 4'd4, 8'h00, 8'h03},
    {OP_POP, 4'd4, 8'h00, 8'h51},
    {OP_POP, 4'd4, 8'h00, 8'hFF},
    {OP_CTL, 4'd4, 8'h0E, 8'h00},
    {OP_CFG, 4'd4, 8'h00, 8'h00}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // every task starts and ends on a falling edge
  task automatic push_rx(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic pop_chk(input string r, input logic [7:0] e);
    data_rd = 1'b1; #1 chk(r, rd_data, e);
    @(negedge clk); data_rd = 1'b0;
  endtask
  task automatic ctl_write(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0;
  endtask
  task automatic lsr_chk(input string r, input logic [1:0] e);
    lsr_rd = 1'b1; #1 chk(r, {ovr, dr}, e);
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ctl", ctl_q, 8'h00);
    chk("R1 count", cnt, 0);
    chk("R1 status", {ovr, dr}, 2'b00);
    chk("R1 rdata", rd_data, 8'hFF);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VEC[i][19:16], i);
      case (VEC[i][23:20])
        OP_PUSH: push_rx(VEC[i][15:8]);
        OP_POP:  pop_chk(rq, VEC[i][7:0]);
        OP_CTL:  ctl_write(VEC[i][15:8]);
        OP_CNT:  chk(rq, cnt, VEC[i][7:0]);
        OP_STAT: chk(rq, {ovr, dr}, VEC[i][1:0]);
        OP_LSR:  lsr_chk(rq, VEC[i][1:0]);
        OP_CFG:  chk(rq, ctl_q, VEC[i][7:0]);
        default: ;
      endcase
    end

    // R3 R6 R13: fill, overflow, wrap
    ctl_write(8'h01);
    for (int i = 0; i < 16; i++) push_rx(8'h80 + 8'(i));
    chk("R6 full count", cnt, 16);
    push_rx(8'hEE);
    chk("R6 overrun", ovr, 1'b1);
    chk("R6 count kept", cnt, 16);
    for (int i = 0; i < 8; i++) pop_chk("R3 order", 8'h80 + 8'(i));
    for (int i = 0; i < 8; i++) push_rx(8'h90 + 8'(i));
    chk("R13 refill", cnt, 16);
    for (int i = 0; i < 8; i++) pop_chk("R13 wrap a", 8'h88 + 8'(i));
    for (int i = 0; i < 8; i++) pop_chk("R13 wrap b", 8'h90 + 8'(i));
    chk("R13 drained", cnt, 0);
    lsr_chk("R8 read", 2'b10);
    chk("R8 cleared", ovr, 1'b0);

    // R10 push and pop together
    push_rx(8'h61);
    rx_valid = 1'b1; rx_data = 8'h62; data_rd = 1'b1;
    #1 chk("R10 head", rd_data, 8'h61);
    @(negedge clk); rx_valid = 1'b0; data_rd = 1'b0;
    chk("R10 level", cnt, 1);
    pop_chk("R10 next", 8'h62);
    for (int i = 0; i < 16; i++) push_rx(8'hA0 + 8'(i));
    rx_valid = 1'b1; rx_data = 8'hB0; data_rd = 1'b1;
    #1 chk("R10 full head", rd_data, 8'hA0);
    @(negedge clk); rx_valid = 1'b0; data_rd = 1'b0;
    chk("R10 full level", cnt, 16);
    chk("R10 no overrun", ovr, 1'b0);

    // R8 drop wins over clearing read
    rx_valid = 1'b1; rx_data = 8'hC1; lsr_rd = 1'b1;
    #1 chk("R8 pre", {ovr, dr}, 2'b01);
    @(negedge clk); rx_valid = 1'b0; lsr_rd = 1'b0;
    chk("R8 set wins", ovr, 1'b1);
    pop_chk("R8 head kept", 8'hA1);

    // R12 flush beats same-cycle push
    ctl_wr = 1'b1; ctl_wdata = 8'h03; rx_valid = 1'b1; rx_data = 8'hD1;
    @(negedge clk); ctl_wr = 1'b0; rx_valid = 1'b0;
    chk("R12 flushed", cnt, 0);
    lsr_chk("R12 status", 2'b10);

    // R11 source select
    loop_en = 1'b1;
    push_rx(8'h71);
    chk("R11 rx ignored", cnt, 0);
    tx_wr = 1'b1; tx_data = 8'h72;
    @(negedge clk); tx_wr = 1'b0;
    chk("R11 tx taken", cnt, 1);
    pop_chk("R11 loop data", 8'h72);
    loop_en = 1'b0;
    tx_wr = 1'b1; tx_data = 8'h73;
    @(negedge clk); tx_wr = 1'b0;
    chk("R11 tx ignored", cnt, 0);
    chk("R7 not ready", dr, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule